// File: doc/BRIEF.md
# External Bus Slave with Wait Insertion

This block is a memory-mapped peripheral on a microcontroller's asynchronous external memory bus. It has three active-low region selects. The first select arrives already narrowed to the lower half of its region. The bus master reaches a bank of four 16-bit registers through any of the three selects. An access qualified by the read or write strobe, with one or both byte-lane selects, reads or writes 8 or 16 bits.

Accesses under the first select can be stretched. A programmable number of clock cycles of internal wait is inserted there. The active-low wait output merges this internal request with the wait request of a neighbouring device that shares the bus. Accesses under the other two selects are never stretched by the block.

The block also raises an interrupt request. It does so while any latched event bit that has been enabled is still set. Software clears event bits by writing ones to them.

Top module: `ext_bus_slave`

## Requirements
- R1: After the active-low reset, all four registers read 0, `waitN` is high, `irqOut` is low and `dataOe` is low.
- R2: Address bits [2:1] select the register. The codes are 0 control, 1 event status, 2 event enable and 3 scratch. Control, enable and scratch hold all 16 written bits and read them back.
- R3: `beN[0]` low selects data bits [7:0] and `beN[1]` low selects bits [15:8]. A write changes only the selected bytes. A read returns 0 on any unselected byte.
- R4: Control bits [3:0] hold a wait count N, from 0 to 15. An access is active under `csN[0]` (first region) when `oeN` or `weN` is low. From the first clock edge at which that access is active, `waitN` is held low for exactly N clock cycles, provided `nbrWaitN` is high.
- R5: Accesses under `csN[1]` or `csN[2]` never pull `waitN` low. They reach the same registers.
- R6: `waitN` is low in every cycle in which `nbrWaitN` is low, whatever the state of the bus.
- R7: When a stretched first-region access ends early because its strobe or select goes inactive, `waitN` goes high in the same cycle, provided `nbrWaitN` is high.
- R8: A high bit on `evtIn` at a clock edge sets the same bit of the status register. Writing 1 to a status bit clears it. If an event and a clear hit the same bit at the same edge, the event wins.
- R9: `irqOut` is high exactly while (status AND enable) is nonzero.
- R10: A strobe with all three selects high writes nothing and keeps `dataOe` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor bus clock |
| rstN | input | 1 | Global active-low reset |
| csN | input | 3 | Active-low selects: bit 0 first region (lower half only), bits 1 and 2 the other regions |
| addr | input | 2 | Address bits [2:1], register index |
| beN | input | 2 | Active-low byte-lane selects |
| oeN | input | 1 | Active-low read strobe |
| weN | input | 1 | Active-low write strobe |
| dataIn | input | 16 | Write data from the bus |
| dataOut | output | 16 | Read data to the bus |
| dataOe | output | 1 | High while read data is being driven |
| nbrWaitN | input | 1 | Active-low wait request of the neighbouring device |
| waitN | output | 1 | Merged active-low wait to the processor |
| evtIn | input | 16 | Event inputs, one per status bit |
| irqOut | output | 1 | Interrupt request, active high |

## Verification
The most serious fault is a wait counter that fails to clear or reload. It shows up at once as `waitN` held low longer than N cycles, or as `waitN` low under the other two selects. A stuck counter would stall every later access. It would therefore show within the 20-cycle window of the next access, and the sweep over all 16 counts exposes an off-by-one on the first access that uses that count. A wrong byte-mask or event-priority state shows up on the next readback of the affected register. A wrong enable or status shows up on `irqOut` one cycle after the event or write that should have changed it.

// File: rtl/ebs_pkg.sv
package ebs_pkg;
  // Strobes from the bus-cycle control to the register datapath.
  typedef struct packed {
    logic commitWr;  // one-cycle write commit
    logic readEn;    // read data must be driven
  } ebsStrobeT;
endpackage

// File: rtl/ebs_ctrl.sv
module ebs_ctrl
  import ebs_pkg::*;
#(
  parameter int CS_W   = 3,
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CS_W-1:0]   csN,
  input  logic              oeN,
  input  logic              weN,
  input  logic [WAIT_W-1:0] waitCount,
  output ebsStrobeT         strobe,
  output logic              intWaitN
);
  logic anySel, strobeOn, access, firstAccess;
  logic seen, done;
  logic [WAIT_W-1:0] waitCnt;

  assign anySel      = ~&csN;
  assign strobeOn    = ~oeN | ~weN;
  assign access      = anySel & strobeOn;
  assign firstAccess = ~csN[0] & strobeOn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seen    <= 1'b0;
      done    <= 1'b0;
      waitCnt <= '0;
    end else if (!access) begin
      seen    <= 1'b0;
      done    <= 1'b0;
      waitCnt <= '0;
    end else if (!seen) begin
      seen    <= 1'b1;
      waitCnt <= firstAccess ? waitCount : '0;
    end else if (waitCnt != '0) begin
      waitCnt <= waitCnt - 1'b1;
    end else if (!done) begin
      done <= 1'b1;
    end
  end

  assign strobe.commitWr = access & seen & (waitCnt == '0) & ~done & ~weN;
  assign strobe.readEn   = access & ~oeN;
  assign intWaitN        = ~(firstAccess & (waitCnt != '0));
endmodule

// File: rtl/ebs_datapath.sv
module ebs_datapath
  import ebs_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 2,
  parameter int WAIT_W = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  ebsStrobeT           strobe,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W/8-1:0] beN,
  input  logic [DATA_W-1:0]   dataIn,
  input  logic [DATA_W-1:0]   evtIn,
  output logic [DATA_W-1:0]   dataOut,
  output logic                dataOe,
  output logic [WAIT_W-1:0]   waitCount,
  output logic                irqOut
);
  localparam int LANES = DATA_W / 8;
  localparam logic [ADDR_W-1:0] IDX_CTRL = 0;
  localparam logic [ADDR_W-1:0] IDX_STAT = 1;
  localparam logic [ADDR_W-1:0] IDX_EN   = 2;
  localparam logic [ADDR_W-1:0] IDX_SCR  = 3;

  logic [DATA_W-1:0] ctrlReg, statReg, enReg, scrReg;
  logic [DATA_W-1:0] laneMask, wrMask, rdWord, clrBits;

  for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
    assign laneMask[lane*8 +: 8] = {8{~beN[lane]}};
  end

  assign wrMask  = strobe.commitWr ? laneMask : '0;
  assign clrBits = (addr == IDX_STAT) ? (dataIn & wrMask) : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
      statReg <= '0;
      enReg   <= '0;
      scrReg  <= '0;
    end else begin
      statReg <= (statReg & ~clrBits) | evtIn;
      if (addr == IDX_CTRL) ctrlReg <= (ctrlReg & ~wrMask) | (dataIn & wrMask);
      if (addr == IDX_EN)   enReg   <= (enReg & ~wrMask) | (dataIn & wrMask);
      if (addr == IDX_SCR)  scrReg  <= (scrReg & ~wrMask) | (dataIn & wrMask);
    end
  end

  always_comb begin
    case (addr)
      IDX_CTRL: rdWord = ctrlReg;
      IDX_STAT: rdWord = statReg;
      IDX_EN:   rdWord = enReg;
      default:  rdWord = scrReg;
    endcase
  end

  assign dataOut   = strobe.readEn ? (rdWord & laneMask) : '0;
  assign dataOe    = strobe.readEn;
  assign waitCount = ctrlReg[WAIT_W-1:0];
  assign irqOut    = |(statReg & enReg);
endmodule

// File: rtl/ext_bus_slave.sv
module ext_bus_slave
  import ebs_pkg::*;
#(
  parameter int CS_W   = 3,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 2,
  parameter int WAIT_W = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [CS_W-1:0]     csN,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W/8-1:0] beN,
  input  logic                oeN,
  input  logic                weN,
  input  logic [DATA_W-1:0]   dataIn,
  output logic [DATA_W-1:0]   dataOut,
  output logic                dataOe,
  input  logic                nbrWaitN,
  output logic                waitN,
  input  logic [DATA_W-1:0]   evtIn,
  output logic                irqOut
);
  ebsStrobeT         strobe;
  logic [WAIT_W-1:0] waitCount;
  logic              intWaitN;

  ebs_ctrl #(.CS_W(CS_W), .WAIT_W(WAIT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .oeN(oeN), .weN(weN),
    .waitCount(waitCount), .strobe(strobe), .intWaitN(intWaitN)
  );

  ebs_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .WAIT_W(WAIT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .addr(addr), .beN(beN),
    .dataIn(dataIn), .evtIn(evtIn), .dataOut(dataOut), .dataOe(dataOe),
    .waitCount(waitCount), .irqOut(irqOut)
  );

  assign waitN = nbrWaitN & intWaitN;
endmodule

// File: rtl/ebs_checker.sv
module ebs_checker #(
  parameter int CS_W   = 3,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic [CS_W-1:0]   csN,
  input logic              oeN,
  input logic              weN,
  input logic              nbrWaitN,
  input logic              waitN,
  input logic              dataOe,
  input logic [DATA_W-1:0] evtIn,
  input logic              irqOut
);
  logic [4:0] lowRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lowRun <= '0;
    else if (!waitN && nbrWaitN && lowRun != 5'd31) lowRun <= lowRun + 1'b1;
    else if (waitN || !nbrWaitN) lowRun <= '0;
  end

  // R4: internal wait never lasts beyond the largest count
  assert_wait_bounded_R4: assert property (@(posedge clk) disable iff (!rstN)
    lowRun <= 5'd15);

  // R5 and R7: without an active first-region access, only the neighbour can hold wait
  assert_wait_first_only_R5: assert property (@(posedge clk) disable iff (!rstN)
    (nbrWaitN && (csN[0] || (oeN && weN))) |-> waitN);

  // R6: neighbour wait always passes through
  assert_nbr_merge_R6: assert property (@(posedge clk) disable iff (!rstN)
    !nbrWaitN |-> !waitN);

  // R10: no data driven without a select
  assert_no_sel_no_drive_R10: assert property (@(posedge clk) disable iff (!rstN)
    (&csN) |-> !dataOe);

  // R9: interrupt only rises after an event or a write
  assert_irq_cause_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> ($past(evtIn) != '0 || !$past(weN)));
endmodule

bind ext_bus_slave ebs_checker #(.CS_W(CS_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .oeN(oeN), .weN(weN),
  .nbrWaitN(nbrWaitN), .waitN(waitN), .dataOe(dataOe),
  .evtIn(evtIn), .irqOut(irqOut)
);

// File: tb/ext_bus_slave_bench.sv
module ext_bus_slave_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  csN = 3'b111;
  logic [1:0]  addr = '0;
  logic [1:0]  beN = 2'b11;
  logic        oeN = 1'b1, weN = 1'b1;
  logic [15:0] dataIn = '0, evtIn = '0;
  logic        nbrWaitN = 1'b1;
  logic [15:0] dataOut;
  logic        dataOe, waitN, irqOut;

  int vectors = 0, misses = 0;

  localparam logic [2:0] SEL0 = 3'b110, SEL2 = 3'b101, SEL3 = 3'b011, NOSEL = 3'b111;

  ext_bus_slave u_ext_bus_slave (
    .clk(clk), .rstN(rstN), .csN(csN), .addr(addr), .beN(beN), .oeN(oeN),
    .weN(weN), .dataIn(dataIn), .dataOut(dataOut), .dataOe(dataOe),
    .nbrWaitN(nbrWaitN), .waitN(waitN), .evtIn(evtIn), .irqOut(irqOut)
  );

  always #4 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic access(input logic [2:0] cs, input bit wr, input logic [1:0] a,
                        input logic [15:0] d, input logic [1:0] be,
                        output logic [15:0] rd, output int waits);
    @(negedge clk);
    csN = cs; addr = a; dataIn = d; beN = be;
    if (wr) weN = 1'b0; else oeN = 1'b0;
    waits = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!waitN) waits++;
    end
    rd = dataOut;
    csN = NOSEL; weN = 1'b1; oeN = 1'b1; beN = 2'b11;
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] cs, input logic [1:0] a, input logic [15:0] d,
                    input logic [1:0] be);
    logic [15:0] r; int w;
    access(cs, 1'b1, a, d, be, r, w);
  endtask

  function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] d,
                                         input logic [1:0] be);
    logic [15:0] m;
    m = {{8{~be[1]}}, {8{~be[0]}}};
    return (old & ~m) | (d & m);
  endfunction

  initial begin
    #(8 * 200000);
    misses++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    logic [15:0] rd, mdl [4];
    logic [2:0]  sels [3];
    logic [1:0]  bes [3];
    int w;
    sels[0] = SEL0; sels[1] = SEL2; sels[2] = SEL3;
    bes[0] = 2'b00; bes[1] = 2'b10; bes[2] = 2'b01;
    for (int i = 0; i < 4; i++) mdl[i] = '0;

    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 waitN", waitN, 1);
    check("R1 irqOut", irqOut, 0);
    check("R1 dataOe", dataOe, 0);
    rstN = 1'b1;
    for (int r = 0; r < 4; r++) begin
      access(SEL2, 1'b0, r[1:0], '0, 2'b00, rd, w);
      check("R1 reg zero", rd, 0);
    end

    // R4, R5: wait count sweep
    for (int n = 0; n < 16; n++) begin
      wr(SEL2, 2'd0, 16'h5a50 | n[15:0], 2'b00);
      access(SEL0, 1'b0, 2'd3, '0, 2'b00, rd, w);
      check("R4 wait cycles first region read", w, n);
      access(SEL0, 1'b1, 2'd3, 16'h1111 * n[15:0], 2'b00, rd, w);
      check("R4 wait cycles first region write", w, n);
      access(SEL2, 1'b0, 2'd3, '0, 2'b00, rd, w);
      check("R4 write committed after wait", rd, 16'h1111 * n);
      check("R5 no wait second region", w, 0);
      access(SEL3, 1'b0, 2'd0, '0, 2'b00, rd, w);
      check("R5 no wait third region", w, 0);
      check("R2 control readback", rd, 16'h5a50 | n);
    end
    mdl[0] = 16'h5a5f; mdl[3] = 16'h1111 * 15;

    // R2, R3: write/read sweep over regions, registers and lanes
    for (int s = 0; s < 3; s++)
      for (int r = 2; r < 4; r++)
        for (int b = 0; b < 3; b++) begin
          logic [15:0] d;
          d = 16'h3c00 + 16'(s * 256 + r * 16 + b) ^ 16'ha5c3;
          wr(sels[s], r[1:0], d, bes[b]);
          mdl[r] = merge(mdl[r], d, bes[b]);
          access(sels[(s + 1) % 3], 1'b0, r[1:0], '0, 2'b00, rd, w);
          check("R3 lane write R2 readback", rd, mdl[r]);
          access(sels[s], 1'b0, r[1:0], '0, bes[b], rd, w);
          check("R3 unselected lane reads zero", rd, mdl[r] & {{8{~bes[b][1]}}, {8{~bes[b][0]}}});
        end

    // R10: no select, nothing written or driven
    wr(NOSEL, 2'd3, 16'hdead, 2'b00);
    @(negedge clk); csN = NOSEL; oeN = 1'b0; addr = 2'd3; beN = 2'b00;
    @(negedge clk);
    check("R10 no drive", dataOe, 0);
    oeN = 1'b1; beN = 2'b11;
    access(SEL3, 1'b0, 2'd3, '0, 2'b00, rd, w);
    check("R10 scratch unchanged", rd, mdl[3]);

    // R7: early end of a stretched access releases wait at once
    @(negedge clk); csN = SEL0; oeN = 1'b0; addr = 2'd3; beN = 2'b00;
    repeat (3) @(negedge clk);
    check("R7 wait held mid access", waitN, 0);
    oeN = 1'b1; #1;
    check("R7 wait released on strobe end", waitN, 1);
    csN = NOSEL; beN = 2'b11;
    repeat (2) @(negedge clk);

    // R6: neighbour wait merged
    nbrWaitN = 1'b0; @(negedge clk);
    check("R6 idle merge", waitN, 0);
    access(SEL2, 1'b0, 2'd3, '0, 2'b00, rd, w);
    check("R6 merge during access", w, 20);
    nbrWaitN = 1'b1; @(negedge clk);
    check("R6 release", waitN, 1);

    // R8, R9: events, enable, clear
    wr(SEL2, 2'd2, 16'h0000, 2'b00);
    @(negedge clk); evtIn = 16'h0001; @(negedge clk); evtIn = '0;
    access(SEL2, 1'b0, 2'd1, '0, 2'b00, rd, w);
    check("R8 event sets status", rd, 16'h0001);
    check("R9 masked no irq", irqOut, 0);
    wr(SEL3, 2'd2, 16'h0001, 2'b00);
    check("R9 enabled irq", irqOut, 1);
    wr(SEL2, 2'd1, 16'h0001, 2'b00);
    check("R9 irq drops after clear", irqOut, 0);
    access(SEL2, 1'b0, 2'd1, '0, 2'b00, rd, w);
    check("R8 write one clears", rd, 16'h0000);
    // R8: event wins over clear at the same edge (commit at second edge)
    @(negedge clk); csN = SEL2; addr = 2'd1; dataIn = 16'h0002; beN = 2'b00; weN = 1'b0;
    @(negedge clk); evtIn = 16'h0002;
    @(negedge clk); evtIn = '0;
    repeat (5) @(negedge clk);
    csN = NOSEL; weN = 1'b1; beN = 2'b11;
    @(negedge clk);
    access(SEL2, 1'b0, 2'd1, '0, 2'b00, rd, w);
    check("R8 event beats clear", rd, 16'h0002);
    wr(SEL2, 2'd2, 16'h0002, 2'b00);
    check("R9 irq from second bit", irqOut, 1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule